// File: doc/BRIEF.md
# Oversampling Bit Synchronizer

This block recovers bit timing from a demodulated serial stream. A rate generator divides the reference clock by a 6-bit divider K and a power-of-two prescaler 2^(7-S). The result is a one-cycle sample enable that runs at sixteen times the bit rate. On each sample enable a 4-bit phase counter advances. Every data transition seen on a sample nudges the counter one step toward the point where a bit boundary lines up with phase zero. Because of this, the mid-bit phase settles in the centre of each received symbol.

The block regenerates a data clock. That clock is high during the second half of the phase cycle. The retimed bit is captured and presented on the same sample where the data clock rises, so a host can read the data on the clock's falling edge. The raw input first passes through a short flop synchronizer. A single enable, asserted only while receiving in synchronous mode, runs the block. While the enable is low, all state is cleared and both outputs are held low.

Top module: `bit_sync`

## Requirements
- R1: The sample enable repeats every N = max(K,1) x 2^(7-S) reference cycles, where K is `div_k` and S is `div_s`. A K of 0 behaves as 1. With a constant input, `data_clk` has a period of 16N reference cycles.
- R2: After `sync_en` is raised with a constant low input, `data_clk` first reads high after the 8N-th rising reference edge. The first enabled edge counts as edge one.
- R3: During reset, and from the first reference edge at which `sync_en` is sampled low, `data_clk` and `data_out` are low. Toggling `rx_data` while disabled does not change them.
- R4: While the block is enabled, `data_out` changes only on an edge where `data_clk` rises. With a constant low input it stays low.
- R5: `data_clk` changes only on a sample enable. With a constant input, it is high for 8N of every 16N reference cycles.
- R6: Take the default parameters, N=1, and a locked loop. An input change made between edges is followed by `data_clk` reading low after the 10th reference edge and high after the 11th. `data_out` shows the previous bit after the 10th edge and the new bit after the 11th.
- R7: Take an alternating input at the exact bit rate, starting at any phase relative to enable. After 22 symbols, the loop meets the R6 timing on every following symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Runs the synchronizer; low clears it |
| div_k | input | 6 | Shared rate divider K (0 treated as 1) |
| div_s | input | 3 | Prescaler setting S, divide by 2^(7-S) |
| rx_data | input | 1 | Raw demodulated data |
| data_clk | output | 1 | Regenerated data clock |
| data_out | output | 1 | Retimed data, updated on data_clk rise |

## Verification
Each internal fault shows up at the ports on a predictable schedule:
- A wrong rate counter stretches or shrinks the `data_clk` period within one 16N-cycle period.
- A wrongly cleared phase counter moves the first data clock rise away from edge 8N.
- A bad nudge direction or step size leaves the loop off-centre. This appears as a misplaced `data_clk` rise, or a wrong captured bit, within the first few checked symbols after the 22-symbol lock window.
- A retiming stage that loads at the wrong time changes `data_out` while `data_clk` is not rising, on the very next bit.

// File: rtl/bit_sync_pkg.sv
package bit_sync_pkg;

   // Correction applied to the phase counter on one sample enable
   typedef enum logic [1:0] {
      STEP_NORMAL = 2'd0,   // advance by one
      STEP_HOLD   = 2'd1,   // stay put (transition arrived late)
      STEP_SKIP   = 2'd2    // advance by two (transition arrived early)
   } step_e;

   typedef struct packed {
      logic [5:0] k;
      logic [2:0] s;
   } rate_cfg_t;

endpackage

// File: rtl/bit_sync_rate.sv
module bit_sync_rate #(
   parameter int K_W = 6,
   parameter int S_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic [K_W-1:0] div_k,
   input  logic [S_W-1:0] div_s,
   output logic           samp_en
);

   localparam int PRE_MAX = (1 << S_W) - 1;
   localparam logic [PRE_MAX-1:0] P_ONES = '1;

   logic [K_W-1:0]     k_cnt;
   logic [K_W-1:0]     k_eff;
   logic [K_W-1:0]     k_last;
   logic [PRE_MAX-1:0] p_cnt;
   logic [PRE_MAX-1:0] p_last;
   logic               k_tick;
   logic               p_wrap;

   assign k_eff  = (div_k == '0) ? K_W'(1) : div_k;
   assign k_last = k_eff - K_W'(1);
   // 2^(PRE_MAX-S) - 1 is the all-ones word shifted right by S
   assign p_last = P_ONES >> div_s;

   assign k_tick  = run && (k_cnt >= k_last);
   assign p_wrap  = p_cnt >= p_last;
   assign samp_en = k_tick && p_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_cnt <= '0;
      end else if (!run || k_tick) begin
         k_cnt <= '0;
      end else begin
         k_cnt <= k_cnt + K_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cnt <= '0;
      end else if (!run) begin
         p_cnt <= '0;
      end else if (k_tick) begin
         if (p_wrap) begin
            p_cnt <= '0;
         end else begin
            p_cnt <= p_cnt + PRE_MAX'(1);
         end
      end
   end

endmodule

// File: rtl/bit_sync_phase.sv
module bit_sync_phase
   import bit_sync_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   localparam int PH_W       = $clog2(OVS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            samp_en,
   input  logic            rx_in,
   output logic            rx_bit,
   output logic [PH_W-1:0] ph_next
);

   localparam logic [PH_W-1:0] MID = PH_W'(OVS / 2);

   logic            rx_s;
   logic            prev_bit;
   logic            trans;
   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] ph_inc;
   step_e           step;

   // Input synchronizer: depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rx_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= rx_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= 1'b0;
                  else        chain[i] <= chain[i-1];
               end
            end
         end
         assign rx_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign rx_bit = rx_s;
   assign trans  = rx_s != prev_bit;
   assign ph_inc = phase + PH_W'(1);

   // A boundary ideally lands where the count wraps to zero
   always_comb begin
      if (!trans || ph_inc == '0) begin
         step = STEP_NORMAL;
      end else if (ph_inc <= MID) begin
         step = STEP_HOLD;
      end else begin
         step = STEP_SKIP;
      end
   end

   always_comb begin
      unique case (step)
         STEP_HOLD: ph_next = phase;
         STEP_SKIP: ph_next = phase + PH_W'(2);
         default:   ph_next = ph_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         prev_bit <= 1'b0;
      end else if (!run) begin
         phase    <= '0;
         prev_bit <= 1'b0;
      end else if (samp_en) begin
         phase    <= ph_next;
         prev_bit <= rx_s;
      end
   end

endmodule

// File: rtl/bit_sync_retime.sv
module bit_sync_retime (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic samp_en,
   input  logic ph_msb,
   input  logic bit_in,
   output logic data_clk,
   output logic data_out
);

   logic clk_q;
   logic data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q  <= 1'b0;
         data_q <= 1'b0;
      end else if (!run) begin
         clk_q  <= 1'b0;
         data_q <= 1'b0;
      end else if (samp_en) begin
         clk_q <= ph_msb;
         if (ph_msb && !clk_q) begin
            data_q <= bit_in;
         end
      end
   end

   assign data_clk = clk_q;
   assign data_out = data_q;

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int K_W         = 6,
   parameter int S_W         = 3,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sync_en,
   input  logic [K_W-1:0] div_k,
   input  logic [S_W-1:0] div_s,
   input  logic           rx_data,
   output logic           data_clk,
   output logic           data_out
);

   localparam int PH_W = $clog2(OVS);

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two of at least 4");
      end
      if (S_W < 1 || S_W > 4) begin : g_bad_sw
         $error("S_W must lie between 1 and 4");
      end
      if (K_W < 1) begin : g_bad_kw
         $error("K_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic            samp_en;
   logic            rx_bit;
   logic [PH_W-1:0] ph_next;

   bit_sync_rate #(
      .K_W (K_W),
      .S_W (S_W)
   ) rate_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (sync_en),
      .div_k   (div_k),
      .div_s   (div_s),
      .samp_en (samp_en)
   );

   bit_sync_phase #(
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) phase_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (sync_en),
      .samp_en (samp_en),
      .rx_in   (rx_data),
      .rx_bit  (rx_bit),
      .ph_next (ph_next)
   );

   bit_sync_retime retime_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sync_en),
      .samp_en  (samp_en),
      .ph_msb   (ph_next[PH_W-1]),
      .bit_in   (rx_bit),
      .data_clk (data_clk),
      .data_out (data_out)
   );

endmodule

// File: rtl/bit_sync_chk.sv
module bit_sync_chk #(
   parameter int K_W = 6,
   parameter int S_W = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sync_en,
   input logic [K_W-1:0] div_k,
   input logic [S_W-1:0] div_s,
   input logic           samp_en,
   input logic           data_clk,
   input logic           data_out
);

   localparam int PRE_MAX = (1 << S_W) - 1;
   localparam int GAP_W   = K_W + PRE_MAX + 1;

   logic [K_W-1:0]     k_eff;
   logic [GAP_W-1:0]   n_exp;
   logic [GAP_W-1:0]   gap;
   logic               armed;
   logic [K_W+S_W-1:0] cfg_q;
   logic               cfg_chg;

   assign k_eff   = (div_k == '0) ? K_W'(1) : div_k;
   assign n_exp   = GAP_W'(k_eff) << (S_W'(PRE_MAX) - div_s);
   assign cfg_chg = {div_k, div_s} != cfg_q;

   // Cycles since the previous sample enable under an unchanged setting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap   <= '0;
         armed <= 1'b0;
         cfg_q <= '0;
      end else begin
         cfg_q <= {div_k, div_s};
         if (!sync_en || cfg_chg) begin
            gap   <= '0;
            armed <= 1'b0;
         end else if (samp_en) begin
            gap   <= GAP_W'(1);
            armed <= 1'b1;
         end else begin
            gap <= gap + GAP_W'(1);
         end
      end
   end

   p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && armed) |-> (gap == n_exp));

   p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_en |=> (!data_clk && !data_out));

   p_data_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_en && $past(sync_en) && !$stable(data_out)) |-> $rose(data_clk));

   p_clk_on_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync_en) && !$stable(data_clk)) |-> $past(samp_en));

endmodule

bind bit_sync bit_sync_chk #(
   .K_W (K_W),
   .S_W (S_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_en  (sync_en),
   .div_k    (div_k),
   .div_s    (div_s),
   .samp_en  (samp_en),
   .data_clk (data_clk),
   .data_out (data_out)
);

// File: tb/bit_sync_tb_top.sv
module bit_sync_tb_top;

   localparam int OVS     = 16;
   localparam int SYNC    = 2;
   localparam int LAT_LO  = SYNC + OVS / 2;
   localparam int LAT_HI  = LAT_LO + 1;

   typedef struct packed {
      logic [5:0]  k;
      logic [2:0]  s;
      logic [31:0] n;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{6'd1,  3'd7, 32'd1},
      '{6'd0,  3'd7, 32'd1},
      '{6'd3,  3'd7, 32'd3},
      '{6'd2,  3'd6, 32'd4},
      '{6'd5,  3'd5, 32'd20},
      '{6'd63, 3'd7, 32'd63}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_en = 1'b0;
   logic [5:0] div_k = 6'd1;
   logic [2:0] div_s = 3'd7;
   logic       rx_data = 1'b0;
   logic       data_clk;
   logic       data_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bit_sync dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_en  (sync_en),
      .div_k    (div_k),
      .div_s    (div_s),
      .rx_data  (rx_data),
      .data_clk (data_clk),
      .data_out (data_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // One symbol of 16 reference cycles (N=1), started and ended at a negedge
   task automatic send_symbol(input logic b, input logic prev_b, input bit chk, input string tag);
      rx_data = b;
      for (int c = 1; c <= OVS; c++) begin
         @(posedge clk);
         @(negedge clk);
         if (chk && c == LAT_LO) begin
            check({tag, " clk low before rise"}, int'(data_clk), 0);
            check({tag, " data holds previous bit"}, int'(data_out), int'(prev_b));
         end
         if (chk && c == LAT_HI) begin
            check({tag, " clk rises mid-bit"}, int'(data_clk), 1);
            check({tag, " data shows new bit"}, int'(data_out), int'(b));
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int cnt, rise1, fall, rise2, n, bad;
      logic prevclk, prev_b, b;
      logic [7:0] pat;

      // R3: reset state
      repeat (3) @(negedge clk);
      check("R3 reset data_clk", int'(data_clk), 0);
      check("R3 reset data_out", int'(data_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R2, R5 table walk with a constant low input
      for (int v = 0; v < NV; v++) begin
         sync_en = 1'b0;
         rx_data = 1'b0;
         repeat (4) @(negedge clk);
         div_k = VECS[v].k;
         div_s = VECS[v].s;
         @(negedge clk);
         sync_en = 1'b1;
         n = int'(VECS[v].n);
         cnt = 0; rise1 = -1; fall = -1; rise2 = -1; prevclk = 1'b0; bad = 0;
         while (rise2 < 0 && cnt < 40 * n + 10) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (data_out) bad++;
            if (data_clk && !prevclk) begin
               if (rise1 < 0) rise1 = cnt;
               else           rise2 = cnt;
            end
            if (!data_clk && prevclk && fall < 0) fall = cnt;
            prevclk = data_clk;
         end
         check("R2 first data_clk rise edge", rise1, 8 * n);
         check("R5 data_clk high time", fall - rise1, 8 * n);
         check("R1 data_clk period", rise2 - rise1, 16 * n);
         check("R4 data_out stays low", bad, 0);
      end

      // R7: lock from several starting phases, N=1
      div_k = 6'd1;
      div_s = 3'd7;
      foreach (VECS[d]) begin
         if (d < 3) begin
            sync_en = 1'b0;
            rx_data = 1'b0;
            repeat (4) @(negedge clk);
            sync_en = 1'b1;
            repeat (3 + 5 * d) @(negedge clk);
            prev_b = 1'b0;
            for (int i = 0; i < 25; i++) begin
               b = (i % 2 == 0);
               send_symbol(b, prev_b, i >= 22, "R7");
               prev_b = b;
            end
         end
      end

      // R6: locked data pattern, including repeated bits
      pat = 8'b1011_0011;
      for (int i = 7; i >= 0; i--) begin
         send_symbol(pat[i], prev_b, 1'b1, "R6");
         prev_b = pat[i];
      end

      // R3: disable clears outputs and ignores input activity
      check("R3 data_out high before disable", int'(data_out), 1);
      sync_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R3 data_clk low after disable", int'(data_clk), 0);
      check("R3 data_out low after disable", int'(data_out), 0);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         rx_data = ~rx_data;
         @(posedge clk);
         @(negedge clk);
         if (data_clk || data_out) bad++;
      end
      check("R3 outputs ignore input while disabled", bad, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule